// File: doc/BRIEF.md
# Device Interrupt Routing Table

This block keeps one small interrupt entry for each attached device. Software sets two things per device through a 64-bit register port: the CPU that should receive the interrupt and the vector number it carries. A control word per device holds a mask flag and a pending flag.

Each device signals an interrupt with a single-cycle pulse on its own request line. A pulse that finds its entry unmasked is accepted. Acceptance does three things:

- it masks the entry again at once;
- it marks the entry pending;
- it queues the entry for posting.

The posting port emits one interrupt per cycle. It carries a valid strobe, the target CPU and the vector. When several entries are queued, the lowest device index goes first.

Because acceptance re-masks the entry, each device fires only once until software unmasks it again. The pending flag is cleared only when software writes the dedicated clear bit. Register reads return data one cycle after the access. An access to any offset outside the two register regions returns zero and raises an error strobe.

Top module: `irq_route_table`

## Requirements
- R1: After reset every entry reads back as masked and not pending, with CPU 0 and vector 0, and post_valid is low.
- R2: The routing register of device i sits at byte offset 8*i. A write loads the CPU from data bits 12:8 and the vector from bits 5:0. A read returns those fields in the same bit positions and zero in all other bits.
- R3: The control register of device i sits at byte offset 8*(NUM_DEV+i). A read returns the mask at bit 2 and pending at bit 0, with all other bits zero.
- R4: A control write sets the mask to data bit 2. If data bit 1 is 1, pending clears. If data bit 1 is 0, pending keeps its value.
- R5: A request pulse on a masked device changes neither its mask nor its pending flag and produces no post.
- R6: A request pulse on an unmasked device sets both its mask and its pending flag at the next clock edge.
- R7: An accepted request shows up on the posting port two edges after the request cycle (post_valid high for one cycle per request). It carries the CPU and vector that the entry holds at the edge where the post is issued.
- R8: Accepted requests that are waiting are posted one per cycle, lowest device index first. A device already waiting is not duplicated by a second acceptance.
- R9: An access to an offset that is not a multiple of 8, or that lies at or beyond 8*2*NUM_DEV, returns zero read data and drives reg_err high for exactly the cycle after the access. Such a write changes no state.
- R10: Read data for an access appears on reg_rdata in the cycle after the access and is zero in cycles with no read. reg_err stays low for mapped offsets.
- R11: If a device is accepted in the same cycle as a control write to its own entry, acceptance wins: mask and pending both end up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | NUM_DEV | One request pulse line per device |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the access |
| reg_err | output | 1 | Unmapped-offset strobe, one cycle after the access |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | CPU_W | Target CPU of the post |
| post_vec | output | VEC_W | Vector of the post |

## Verification
A behavioural model in the bench tracks every entry and the waiting set. It is compared with the posting port, the read data and the error strobe on every cycle.

The directed patterns each separate one pair of mistakes:
- A single pulse on one device separates accept from drop.
- A repeated pulse on an already masked entry shows whether re-masking happens.
- A simultaneous burst on devices 0, 5 and 31 exposes the wrong priority order or lost queue entries.
- Writing the clear bit as 0 and then as 1 separates the two pending paths.
- A pulse in the same cycle as a control write shows which side wins the collision.

A long random phase then mixes sparse pulses with reads and writes, including unaligned and out-of-range offsets, to cover orderings the directed cases miss.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   // bit positions of the register fields
   localparam int CPU_LSB  = 8;
   localparam int VEC_LSB  = 0;
   localparam int MASK_BIT = 2;
   localparam int CLR_BIT  = 1;
   localparam int PEND_BIT = 0;
   localparam int SLOT_SH  = 3;

   typedef enum logic [1:0] {
      KIND_ROUTE = 2'd0,
      KIND_CTRL  = 2'd1,
      KIND_NONE  = 2'd2
   } reg_kind_e;
endpackage

// File: rtl/irq_entry.sv
module irq_entry #(
   parameter int CPU_W = 5,
   parameter int VEC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             rt_we_i,
   input  logic             ctl_we_i,
   input  logic [CPU_W-1:0] wcpu_i,
   input  logic [VEC_W-1:0] wvec_i,
   input  logic             wmask_i,
   input  logic             wclr_i,
   output logic [CPU_W-1:0] cpu_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             mask_o,
   output logic             pend_o,
   output logic             accept_o
);
   logic mask_q, pend_q;

   assign accept_o = req_i & ~mask_q;
   assign mask_o   = mask_q;
   assign pend_o   = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_o <= '0;
         vec_o <= '0;
      end else if (rt_we_i) begin
         cpu_o <= wcpu_i;
         vec_o <= wvec_i;
      end
   end

   // acceptance overrides a same-cycle control write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
         pend_q <= 1'b0;
      end else if (accept_o) begin
         mask_q <= 1'b1;
         pend_q <= 1'b1;
      end else if (ctl_we_i) begin
         mask_q <= wmask_i;
         if (wclr_i) pend_q <= 1'b0;
      end
   end

   // R5
   masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && mask_q && !ctl_we_i) |=> (mask_q && $stable(pend_q)));

   // R6
   accept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !mask_q) |=> (mask_q && pend_q));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N     = 32,
   parameter int IDX_W = 5
) (
   input  logic [N-1:0]     req_i,
   output logic [N-1:0]     grant_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   assign any_o   = |req_i;
   assign grant_o = req_i & (~req_i + N'(1));

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
   import irq_route_pkg::*;
#(
   parameter int NUM_DEV = 32,
   parameter int CPU_W   = 5,
   parameter int VEC_W   = 6,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] dev_irq,
   input  logic               reg_en,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [63:0]        reg_wdata,
   output logic [63:0]        reg_rdata,
   output logic               reg_err,
   output logic               post_valid,
   output logic [CPU_W-1:0]   post_cpu,
   output logic [VEC_W-1:0]   post_vec
);
   localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
   localparam int SLOT_W = ADDR_W - SLOT_SH;

   // elaboration-time parameter checks
   if (NUM_DEV < 1)             begin : g_bad_dev  $error("NUM_DEV must be at least 1"); end
   if (CPU_W < 1 || CPU_W > 5)  begin : g_bad_cpu  $error("CPU_W must be 1..5"); end
   if (VEC_W < 1 || VEC_W > 6)  begin : g_bad_vec  $error("VEC_W must be 1..6"); end
   if (SLOT_W < IDX_W + 2)      begin : g_bad_addr $error("ADDR_W too small for two regions"); end

   // ---------------- address decode ----------------
   logic [SLOT_W-1:0] slot, slot_c;
   logic [IDX_W-1:0]  acc_idx;
   reg_kind_e         kind;

   assign slot   = reg_addr[ADDR_W-1:SLOT_SH];
   assign slot_c = slot - SLOT_W'(NUM_DEV);

   always_comb begin
      kind    = KIND_NONE;
      acc_idx = '0;
      if (reg_addr[SLOT_SH-1:0] == '0) begin
         if (slot < SLOT_W'(NUM_DEV)) begin
            kind    = KIND_ROUTE;
            acc_idx = slot[IDX_W-1:0];
         end else if (slot < SLOT_W'(2 * NUM_DEV)) begin
            kind    = KIND_CTRL;
            acc_idx = slot_c[IDX_W-1:0];
         end
      end
   end

   // ---------------- entries ----------------
   logic [CPU_W-1:0]   cpu_a [NUM_DEV];
   logic [VEC_W-1:0]   vec_a [NUM_DEV];
   logic [NUM_DEV-1:0] mask_a, pend_a, accept_a;

   for (genvar i = 0; i < NUM_DEV; i++) begin : g_ent
      logic rt_we, ctl_we;
      assign rt_we  = reg_en && reg_wr && (kind == KIND_ROUTE) && (acc_idx == IDX_W'(i));
      assign ctl_we = reg_en && reg_wr && (kind == KIND_CTRL)  && (acc_idx == IDX_W'(i));

      irq_entry #(.CPU_W(CPU_W), .VEC_W(VEC_W)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_i    (dev_irq[i]),
         .rt_we_i  (rt_we),
         .ctl_we_i (ctl_we),
         .wcpu_i   (reg_wdata[CPU_LSB +: CPU_W]),
         .wvec_i   (reg_wdata[VEC_LSB +: VEC_W]),
         .wmask_i  (reg_wdata[MASK_BIT]),
         .wclr_i   (reg_wdata[CLR_BIT]),
         .cpu_o    (cpu_a[i]),
         .vec_o    (vec_a[i]),
         .mask_o   (mask_a[i]),
         .pend_o   (pend_a[i]),
         .accept_o (accept_a[i])
      );
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // ---------------- read path ----------------
   logic [63:0] rd_val;
   always_comb begin
      rd_val = '0;
      if (kind == KIND_ROUTE) begin
         rd_val[CPU_LSB +: CPU_W] = cpu_a[acc_idx];
         rd_val[VEC_LSB +: VEC_W] = vec_a[acc_idx];
      end else if (kind == KIND_CTRL) begin
         rd_val[MASK_BIT] = mask_a[acc_idx];
         rd_val[PEND_BIT] = pend_a[acc_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         reg_err   <= 1'b0;
      end else begin
         reg_rdata <= (reg_en && !reg_wr) ? rd_val : '0;
         reg_err   <= reg_en && (kind == KIND_NONE);
      end
   end

   // ---------------- waiting set and posting ----------------
   logic [NUM_DEV-1:0] lat_q, grant;
   logic [IDX_W-1:0]   pick_idx;
   logic               pick_any;

   irq_prio_pick #(.N(NUM_DEV), .IDX_W(IDX_W)) u_pick (
      .req_i   (lat_q),
      .grant_o (grant),
      .idx_o   (pick_idx),
      .any_o   (pick_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q      <= '0;
         post_valid <= 1'b0;
         post_cpu   <= '0;
         post_vec   <= '0;
      end else begin
         lat_q      <= (lat_q & ~grant) | accept_a;
         post_valid <= pick_any;
         post_cpu   <= pick_any ? cpu_a[pick_idx] : '0;
         post_vec   <= pick_any ? vec_a[pick_idx] : '0;
      end
   end

   // R7
   post_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid |-> $past(|lat_q));

   // R8
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R8
   grant_matches_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_any |-> grant[pick_idx]);

   // R9
   err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> $past(reg_en));

   // R9
   err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> (reg_rdata == 64'd0));
endmodule

// File: tb/irq_route_table_tb.sv
`timescale 1ns/1ps
module irq_route_table_tb_top;
   localparam int N  = 32;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  dev_irq = '0;
   logic          reg_en = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [63:0]   reg_wdata = '0;
   logic [63:0]   reg_rdata;
   logic          reg_err;
   logic          post_valid;
   logic [4:0]    post_cpu;
   logic [5:0]    post_vec;

   always #2.5 clk = ~clk;

   irq_route_table #(.NUM_DEV(N), .CPU_W(5), .VEC_W(6), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
      .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_err(reg_err),
      .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
   );

   int    total = 0;
   int    bad   = 0;
   string tag   = "R1";
   bit    done  = 0;

   // ---------------- behavioural reference model ----------------
   int          m_cpu [N];
   int          m_vec [N];
   bit          m_mask[N];
   bit          m_pend[N];
   bit          m_wait[N];
   bit          m_pv;
   int          m_pcpu, m_pvec;
   logic [63:0] m_rdata;
   bit          m_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_cpu[i] = 0; m_vec[i] = 0; m_mask[i] = 1; m_pend[i] = 0; m_wait[i] = 0;
         end
         m_pv = 0; m_pcpu = 0; m_pvec = 0; m_rdata = 0; m_err = 0;
      end else begin
         int  first;
         int  kind;
         int  idx;
         bit  acc[N];
         first = -1;
         for (int i = 0; i < N; i++) if (m_wait[i] && first < 0) first = i;
         m_pv   = (first >= 0);
         m_pcpu = m_pv ? m_cpu[first] : 0;
         m_pvec = m_pv ? m_vec[first] : 0;
         // 0 = routing, 1 = control, 2 = unmapped
         kind = 2; idx = 0;
         if (reg_addr[2:0] == 0) begin
            idx = int'(reg_addr) / 8;
            if (idx < N) kind = 0;
            else if (idx < 2 * N) begin kind = 1; idx = idx - N; end
         end
         m_rdata = 0;
         if (reg_en && !reg_wr) begin
            if (kind == 0) m_rdata = 64'(m_cpu[idx]) * 256 + 64'(m_vec[idx]);
            else if (kind == 1) m_rdata = 64'(m_mask[idx]) * 4 + 64'(m_pend[idx]);
         end
         m_err = reg_en && (kind == 2);
         for (int i = 0; i < N; i++) acc[i] = dev_irq[i] && !m_mask[i];
         if (first >= 0) m_wait[first] = 0;
         if (reg_en && reg_wr && kind == 0) begin
            m_cpu[idx] = int'(reg_wdata[12:8]);
            m_vec[idx] = int'(reg_wdata[5:0]);
         end
         if (reg_en && reg_wr && kind == 1) begin
            m_mask[idx] = reg_wdata[2];
            if (reg_wdata[1]) m_pend[idx] = 0;
         end
         for (int i = 0; i < N; i++) if (acc[i]) begin
            m_mask[i] = 1; m_pend[i] = 1; m_wait[i] = 1;
         end
      end
   end

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(post_valid === m_pv, "post_valid", longint'(post_valid), longint'(m_pv));
         if (m_pv) begin
            chk(post_cpu === 5'(m_pcpu), "post_cpu", longint'(post_cpu), longint'(m_pcpu));
            chk(post_vec === 6'(m_pvec), "post_vec", longint'(post_vec), longint'(m_pvec));
         end
         chk(reg_rdata === m_rdata, "reg_rdata", longint'(reg_rdata), longint'(m_rdata));
         chk(reg_err === m_err, "reg_err", longint'(reg_err), longint'(m_err));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int addr, input logic [63:0] d);
      @(negedge clk);
      reg_en = 1; reg_wr = 1; reg_addr = AW'(addr); reg_wdata = d;
      @(negedge clk);
      reg_en = 0; reg_wr = 0;
   endtask

   task automatic rd_chk(input int addr, input logic [63:0] exp, input bit exp_err);
      @(negedge clk);
      reg_en = 1; reg_wr = 0; reg_addr = AW'(addr);
      @(negedge clk);
      reg_en = 0;
      chk(reg_rdata === exp, "read data", longint'(reg_rdata), longint'(exp));
      chk(reg_err === exp_err, "read err", longint'(reg_err), longint'(exp_err));
   endtask

   task automatic pulse(input logic [N-1:0] v);
      @(negedge clk);
      dev_irq = v;
      @(negedge clk);
      dev_irq = '0;
   endtask

   function automatic int ctl(input int i);
      return 8 * (N + i);
   endfunction

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      tag = "R1";
      chk(post_valid === 1'b0, "post_valid after reset", longint'(post_valid), 0);
      rd_chk(0, 64'h0, 0);
      rd_chk(8 * 31, 64'h0, 0);
      rd_chk(ctl(0), 64'h4, 0);
      rd_chk(ctl(31), 64'h4, 0);

      // R2: routing fields
      tag = "R2";
      wr(8 * 3, 64'h0000_0000_0000_0215);
      rd_chk(8 * 3, 64'h215, 0);
      wr(8 * 9, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk(8 * 9, 64'h1F3F, 0);

      // R3 / R4: unmask device 3
      tag = "R4";
      wr(ctl(3), 64'h0);
      rd_chk(ctl(3), 64'h0, 0);

      // R6 / R7: single accepted request
      tag = "R7";
      pulse(N'(1) << 3);
      @(negedge clk);
      chk(post_valid === 1'b1, "single post strobe", longint'(post_valid), 1);
      chk(post_cpu === 5'd2 && post_vec === 6'h15, "single post fields",
          longint'({post_cpu, post_vec}), longint'({5'd2, 6'h15}));
      tag = "R6";
      rd_chk(ctl(3), 64'h5, 0);

      // R5: masked request dropped
      tag = "R5";
      pulse(N'(1) << 3);
      @(negedge clk);
      chk(post_valid === 1'b0, "no post from masked", longint'(post_valid), 0);
      rd_chk(ctl(3), 64'h5, 0);
      pulse(N'(1) << 4);
      rd_chk(ctl(4), 64'h4, 0);

      // R4: clear bit 0 keeps pending, clear bit 1 clears it
      tag = "R4";
      wr(ctl(3), 64'h4);
      rd_chk(ctl(3), 64'h5, 0);
      wr(ctl(3), 64'h6);
      rd_chk(ctl(3), 64'h4, 0);

      // R8: simultaneous burst
      tag = "R8";
      wr(8 * 0,  64'h010A);
      wr(8 * 5,  64'h0214);
      wr(8 * 31, 64'h1F3F);
      wr(ctl(0), 64'h0);
      wr(ctl(5), 64'h0);
      wr(ctl(31), 64'h0);
      pulse((N'(1) << 0) | (N'(1) << 5) | (N'(1) << 31));
      @(negedge clk);
      chk(post_valid && post_vec === 6'h0A, "burst first", longint'(post_vec), 64'h0A);
      @(negedge clk);
      chk(post_valid && post_vec === 6'h14, "burst second", longint'(post_vec), 64'h14);
      @(negedge clk);
      chk(post_valid && post_vec === 6'h3F && post_cpu === 5'd31, "burst third",
          longint'({post_cpu, post_vec}), longint'({5'd31, 6'h3F}));
      @(negedge clk);
      chk(post_valid === 1'b0, "burst drained", longint'(post_valid), 0);

      // R11: acceptance vs same-cycle control write
      tag = "R11";
      wr(ctl(7), 64'h0);
      @(negedge clk);
      dev_irq = N'(1) << 7;
      reg_en = 1; reg_wr = 1; reg_addr = AW'(ctl(7)); reg_wdata = 64'h2;
      @(negedge clk);
      dev_irq = '0; reg_en = 0; reg_wr = 0;
      rd_chk(ctl(7), 64'h5, 0);

      // R9: unmapped offsets
      tag = "R9";
      rd_chk(8 * 2 * N, 64'h0, 1);
      rd_chk(4, 64'h0, 1);
      wr(8 * 2 * N + 16, 64'hFFFF);
      rd_chk(8 * 2, 64'h0, 0);

      // R10 / R8: random mix, checked against the model every cycle
      tag = "R10";
      for (int k = 0; k < 3000; k++) begin
         int r;
         @(negedge clk);
         dev_irq = '0;
         for (int b = 0; b < N; b++) if ($urandom % 24 == 0) dev_irq[b] = 1'b1;
         r = int'($urandom % 10);
         reg_en = (r < 6);
         reg_wr = (r < 3);
         if ($urandom % 12 == 0) reg_addr = AW'($urandom);
         else reg_addr = AW'(8 * ($urandom % (2 * N)));
         reg_wdata = {$urandom, $urandom};
         if ($urandom % 3 == 0) reg_wdata[2] = 1'b0;
      end
      @(negedge clk);
      dev_irq = '0; reg_en = 0; reg_wr = 0;
      repeat (40) @(negedge clk);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule